// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block receives configuration writes over a three-wire serial link (enable, clock, data) and holds them in a bank of ten 32-bit registers. A transfer is delimited by the enable line. While enable is high, every rising edge of the serial clock shifts one bit into a shift register: first an 8-bit register address and then a 32-bit value, each with the most significant bit first. The sender then drops enable and gives one more serial clock pulse. On that trailing edge the block commits the frame, but only if exactly 40 bits arrived.

The register bank sits in the system clock domain. A toggle crosses from the serial domain through a two-flop synchronizer. When the synchronizer sees the toggle change, the bank decodes the held address, writes the held value and raises a one-cycle strobe for the register that was written.

The bank holds four receive-side tuning words, four transmit-side tuning words, a rate word and a control word. All of them are presented as parallel outputs.

Top module: `cfg_serial_bank`

## Requirements
- R1: While sys_rst_n is low, and after it is released until the first commit, every register output is zero and reg_stb is zero.
- R2: Bits are sampled on rising edges of ser_clk taken while ser_en is high. The first 8 bits form the address and the next 32 bits form the data, each sent most significant bit first.
- R3: A frame commits on the first rising ser_clk edge taken while ser_en is low, and only if exactly 40 bits were sampled since the bit count was last cleared. Every rising ser_clk edge taken with ser_en low clears the count. A frame of any other length is discarded.
- R4: Address n, for n from 0 to 3, writes rx_tune[32n+31:32n]. Address 4+n, for n from 0 to 3, writes tx_tune[32n+31:32n].
- R5: Address 8 writes rate_word and address 9 writes ctrl_word.
- R6: A committed frame with an address from 10 to 255 changes no register and raises no strobe.
- R7: A write to address n raises reg_stb[n] for exactly one sys_clk cycle, and no other strobe bit at the same time. The register takes its new value in the same cycle. When the committing ser_clk edge falls midway between sys_clk edges, this happens on the third rising sys_clk edge after it.
- R8: Further ser_clk pulses with ser_en low after a commit cause no second write and no second strobe.
- R9: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the register bank |
| sys_rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_en | input | 1 | Frame enable, high during the 40 bits |
| ser_clk | input | 1 | Serial bit clock, sampling on its rising edge |
| ser_dat | input | 1 | Serial data |
| rx_tune | output | 128 | Four receive tuning words, channel n at bits 32n+31:32n |
| tx_tune | output | 128 | Four transmit tuning words, channel n at bits 32n+31:32n |
| rate_word | output | 32 | Rate register |
| ctrl_word | output | 32 | Control register |
| reg_stb | output | 10 | One-cycle write strobe, bit n for address n |

## Verification
The bench sends frames of 39 and 41 bits. A design that counted loosely would commit a shifted or truncated value into some register, and one of the outputs would change. It writes to addresses 10, 128 and 255. A decoder that looked only at the low address bits would alias these onto real registers and pulse their strobes. It also follows one frame with three trailing pulses, which catches a design that leaves its bit count uncleared and writes twice. Writing distinct values to all ten addresses, with a reference model checked on every cycle, exposes swapped channel slices, wrong bit order and strobes that arrive a cycle early or late.

// File: rtl/cfgbus_pkg.sv
`timescale 1ns/1ps
package cfgbus_pkg;
   localparam int unsigned CFG_ADDR_W_DEF = 8;
   localparam int unsigned CFG_DATA_W_DEF = 32;
   localparam int unsigned CFG_N_CH_DEF   = 4;
   localparam int unsigned CFG_SYNC_DEF   = 2;

   // Width of a bit counter that must reach frame_bits + 1, the overlength marker.
   function automatic int unsigned cfg_cnt_w(input int unsigned frame_bits);
      return $clog2(frame_bits + 2);
   endfunction
endpackage

// File: rtl/cfg_ser_shift.sv
`timescale 1ns/1ps
module cfg_ser_shift
   import cfgbus_pkg::*;
#(
   parameter int unsigned ADDR_W = CFG_ADDR_W_DEF,
   parameter int unsigned DATA_W = CFG_DATA_W_DEF
) (
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_en,
   input  logic              ser_dat,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_data,
   output logic              commit_tgl
);
   localparam int unsigned FRAME_W = ADDR_W + DATA_W;
   localparam int unsigned CNT_W   = cfg_cnt_w(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("cfg_ser_shift: address and data widths must be positive");
      end
   endgenerate

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   bit_cnt;

   // Shift while enabled. With enable low, clear the count and commit only an exact frame.
   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         bit_cnt    <= '0;
         hold_addr  <= '0;
         hold_data  <= '0;
         commit_tgl <= 1'b0;
      end else if (!ser_en) begin
         bit_cnt <= '0;
         if (bit_cnt == CNT_FULL) begin
            hold_addr  <= shreg[FRAME_W-1 -: ADDR_W];
            hold_data  <= shreg[DATA_W-1:0];
            commit_tgl <= ~commit_tgl;
         end
      end else begin
         shreg <= {shreg[FRAME_W-2:0], ser_dat};
         if (bit_cnt != CNT_OVER) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_cdc_pulse.sv
`timescale 1ns/1ps
module cfg_cdc_pulse
   import cfgbus_pkg::*;
#(
   parameter int unsigned STAGES = CFG_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_cdc_pulse: at least two synchronizer stages are needed");
      end
   endgenerate

   // Stages 0..STAGES-1 form the synchronizer, and stage STAGES keeps the previous value.
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-1:0], tgl_in};
      end
   end

   assign pulse_out = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
   import cfgbus_pkg::*;
#(
   parameter int unsigned ADDR_W = CFG_ADDR_W_DEF,
   parameter int unsigned DATA_W = CFG_DATA_W_DEF,
   parameter int unsigned N_REGS = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [N_REGS*DATA_W-1:0] regs,
   output logic [N_REGS-1:0]        stb
);
   generate
      if (N_REGS > (1 << ADDR_W)) begin : g_bad_map
         $error("cfg_reg_bank: more registers than the address can select");
      end
   endgenerate

   logic [N_REGS-1:0] hit;

   generate
      for (genvar g = 0; g < N_REGS; g++) begin : g_reg
         // Compare the full address so that higher addresses never alias onto a register.
         assign hit[g] = wr_en && (wr_addr == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g*DATA_W +: DATA_W] <= '0;
               stb[g]                   <= 1'b0;
            end else begin
               stb[g] <= hit[g];
               if (hit[g]) begin
                  regs[g*DATA_W +: DATA_W] <= wr_data;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_serial_bank.sv
`timescale 1ns/1ps
module cfg_serial_bank
   import cfgbus_pkg::*;
#(
   parameter int unsigned ADDR_W      = CFG_ADDR_W_DEF,
   parameter int unsigned DATA_W      = CFG_DATA_W_DEF,
   parameter int unsigned N_RX        = CFG_N_CH_DEF,
   parameter int unsigned N_TX        = CFG_N_CH_DEF,
   parameter int unsigned SYNC_STAGES = CFG_SYNC_DEF
) (
   input  logic                       sys_clk,
   input  logic                       sys_rst_n,
   input  logic                       ser_en,
   input  logic                       ser_clk,
   input  logic                       ser_dat,
   output logic [N_RX*DATA_W-1:0]     rx_tune,
   output logic [N_TX*DATA_W-1:0]     tx_tune,
   output logic [DATA_W-1:0]          rate_word,
   output logic [DATA_W-1:0]          ctrl_word,
   output logic [N_RX+N_TX+1:0]       reg_stb
);
   localparam int unsigned N_REGS   = N_RX + N_TX + 2;
   localparam int unsigned RATE_IDX = N_RX + N_TX;
   localparam int unsigned CTRL_IDX = RATE_IDX + 1;

   generate
      if (N_RX < 1 || N_TX < 1) begin : g_bad_ch
         $error("cfg_serial_bank: each direction needs at least one channel");
      end
   endgenerate

   logic [ADDR_W-1:0]        hold_addr;
   logic [DATA_W-1:0]        hold_data;
   logic                     commit_tgl;
   logic                     commit_pulse;
   logic [N_REGS*DATA_W-1:0] bank_flat;

   cfg_ser_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .rst_n      (sys_rst_n),
      .ser_clk    (ser_clk),
      .ser_en     (ser_en),
      .ser_dat    (ser_dat),
      .hold_addr  (hold_addr),
      .hold_data  (hold_data),
      .commit_tgl (commit_tgl)
   );

   // The held address and data stay still for many system cycles around each toggle.
   cfg_cdc_pulse #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (sys_clk),
      .rst_n     (sys_rst_n),
      .tgl_in    (commit_tgl),
      .pulse_out (commit_pulse)
   );

   cfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_REGS(N_REGS)) u_bank (
      .clk     (sys_clk),
      .rst_n   (sys_rst_n),
      .wr_en   (commit_pulse),
      .wr_addr (hold_addr),
      .wr_data (hold_data),
      .regs    (bank_flat),
      .stb     (reg_stb)
   );

   assign rx_tune   = bank_flat[N_RX*DATA_W-1:0];
   assign tx_tune   = bank_flat[RATE_IDX*DATA_W-1:N_RX*DATA_W];
   assign rate_word = bank_flat[RATE_IDX*DATA_W +: DATA_W];
   assign ctrl_word = bank_flat[CTRL_IDX*DATA_W +: DATA_W];
endmodule

// File: rtl/cfg_serial_bank_chk.sv
`timescale 1ns/1ps
module cfg_serial_bank_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_REGS = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_REGS-1:0]        reg_stb,
   input logic                     commit_pulse,
   input logic [ADDR_W-1:0]        commit_addr,
   input logic [N_REGS*DATA_W-1:0] bank
);
   // R7
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_stb));

   // R7
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_stb) |=> (reg_stb == '0));

   // R3
   stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_stb) |-> $past(commit_pulse));

   // R6
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_pulse && (int'(commit_addr) >= int'(N_REGS))) |=> (reg_stb == '0));

   generate
      for (genvar g = 0; g < N_REGS; g++) begin : g_hold
         // R9
         bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(bank[g*DATA_W +: DATA_W]) |-> reg_stb[g]);
      end
   endgenerate
endmodule

bind cfg_serial_bank cfg_serial_bank_chk u_chk (
   .clk          (sys_clk),
   .rst_n        (sys_rst_n),
   .reg_stb      (reg_stb),
   .commit_pulse (commit_pulse),
   .commit_addr  (hold_addr),
   .bank         (bank_flat)
);

// File: tb/cfg_serial_bank_bench.sv
`timescale 1ns/1ps
module cfg_serial_bank_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_en = 1'b0;
   logic         ser_clk = 1'b0;
   logic         ser_dat = 1'b0;
   logic [127:0] rx_tune;
   logic [127:0] tx_tune;
   logic [31:0]  rate_word;
   logic [31:0]  ctrl_word;
   logic [9:0]   reg_stb;

   always #2.5 clk = ~clk;

   cfg_serial_bank u_cfg_serial_bank (
      .sys_clk   (clk),
      .sys_rst_n (rst_n),
      .ser_en    (ser_en),
      .ser_clk   (ser_clk),
      .ser_dat   (ser_dat),
      .rx_tune   (rx_tune),
      .tx_tune   (tx_tune),
      .rate_word (rate_word),
      .ctrl_word (ctrl_word),
      .reg_stb   (reg_stb)
   );

   // Reference model
   logic [31:0] m_reg [10];
   logic [9:0]  m_stb;
   int          p_cnt [$];
   int          p_addr [$];
   logic [31:0] p_data [$];
   bit          sbits [$];
   logic        prev_sc = 1'b0;
   string       cur_req = "R1";
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 0;

   task automatic compare();
      logic [127:0] e_rx, e_tx;
      for (int i = 0; i < 4; i++) begin
         e_rx[i*32 +: 32] = m_reg[i];
         e_tx[i*32 +: 32] = m_reg[4+i];
      end
      n_vec++;
      if (rx_tune !== e_rx || tx_tune !== e_tx || rate_word !== m_reg[8] ||
          ctrl_word !== m_reg[9] || reg_stb !== m_stb) begin
         n_bad++;
         $display("FAIL %s: rx=%h tx=%h rate=%h ctrl=%h stb=%b expected rx=%h tx=%h rate=%h ctrl=%h stb=%b",
                  cur_req, rx_tune, tx_tune, rate_word, ctrl_word, reg_stb,
                  e_rx, e_tx, m_reg[8], m_reg[9], m_stb);
      end
   endtask

   // One system cycle: advance the model past the last edge, compare, then drive the serial pins.
   task automatic tick(input logic en, input logic sc, input logic d);
      @(negedge clk);
      m_stb = '0;
      for (int i = 0; i < p_cnt.size(); i++) p_cnt[i]--;
      while (p_cnt.size() > 0 && p_cnt[0] == 0) begin
         if (p_addr[0] < 10) begin
            m_reg[p_addr[0]] = p_data[0];
            m_stb[p_addr[0]] = 1'b1;
         end
         void'(p_cnt.pop_front());
         void'(p_addr.pop_front());
         void'(p_data.pop_front());
      end
      compare();
      if (sc && !prev_sc) begin
         if (!en) begin
            if (sbits.size() == 40) begin
               int a = 0;
               logic [31:0] dv = '0;
               for (int i = 0; i < 8; i++) a = a * 2 + int'(sbits[i]);
               for (int i = 8; i < 40; i++) dv = {dv[30:0], sbits[i]};
               p_cnt.push_back(3);
               p_addr.push_back(a);
               p_data.push_back(dv);
            end
            sbits.delete();
         end else begin
            sbits.push_back(d);
         end
      end
      prev_sc = sc;
      ser_en  = en;
      ser_dat = d;
      ser_clk = sc;
   endtask

   task automatic half(input logic en, input logic sc, input logic d);
      repeat (4) tick(en, sc, d);
   endtask

   task automatic send_frame(input logic [7:0] a, input logic [31:0] d,
                             input int nbits, input int trail);
      logic [40:0] w = {a, d, 1'b0};
      half(1'b1, 1'b0, w[40]);
      for (int i = 0; i < nbits; i++) begin
         half(1'b1, 1'b0, w[40-i]);
         half(1'b1, 1'b1, w[40-i]);
      end
      half(1'b0, 1'b0, 1'b0);
      for (int t = 0; t < trail; t++) begin
         half(1'b0, 1'b1, 1'b0);
         half(1'b0, 1'b0, 1'b0);
      end
      repeat (3) half(1'b0, 1'b0, 1'b0);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #950000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, actual hung expected finished");
         summary();
      end
   end

   initial begin
      for (int i = 0; i < 10; i++) m_reg[i] = '0;
      m_stb = '0;
      // R1: reset state
      cur_req = "R1";
      repeat (10) tick(1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      repeat (10) tick(1'b0, 1'b0, 1'b0);
      // R2 R4 R5 R7 R9: distinct value to every address
      for (int a = 0; a < 10; a++) begin
         cur_req = (a < 8) ? "R4" : "R5";
         send_frame(8'(a), 32'h8E3C_15A7 ^ (32'h0101_0101 * (a + 1)) ^ (32'h1 << (3 * a)), 40, 1);
      end
      cur_req = "R2";
      send_frame(8'd0, 32'hFFFF_FFFF, 40, 1);
      send_frame(8'd9, 32'h8000_0001, 40, 1);
      cur_req = "R9";
      send_frame(8'd6, 32'h0000_0000, 40, 1);
      // R6: unmapped addresses
      cur_req = "R6";
      send_frame(8'd10, 32'hDEAD_BEEF, 40, 1);
      send_frame(8'd128, 32'h1234_5678, 40, 1);
      send_frame(8'd255, 32'hCAFE_F00D, 40, 1);
      // R3: wrong lengths are discarded
      cur_req = "R3";
      send_frame(8'd2, 32'h5555_AAAA, 39, 1);
      send_frame(8'd3, 32'h0F0F_0F0F, 41, 1);
      send_frame(8'd1, 32'h7654_3210, 40, 1);
      // R8: extra trailing pulses
      cur_req = "R8";
      send_frame(8'd5, 32'hA1B2_C3D4, 40, 3);
      // R7: back-to-back writes
      cur_req = "R7";
      send_frame(8'd8, 32'h0000_00FF, 40, 1);
      send_frame(8'd4, 32'hFF00_0000, 40, 1);
      repeat (20) tick(1'b0, 1'b0, 1'b0);
      done = 1;
      summary();
   end
endmodule